// File: doc/BRIEF.md
# Banked Local Memory Address Router

This block sits between a set of requesters and the sixteen banks of a 4 MB shared local memory. Each requester presents a byte address, a read or write flag and 256 bits of write data. The router decides which bank serves the request and which 32-byte row inside that bank is addressed. When several requesters want the same bank in one cycle, a round-robin arbiter for that bank picks one of them. Read data comes back one cycle later on the winning requester's own response lane. The bank storage arrays sit outside the block; the router drives their enables, row indices and write data, and it collects their registered read data.

Two run-time settings select the mapping. In asymmetric mode, bank k owns one contiguous 256 KB window. In symmetric mode, the memory is split at a programmable boundary, counted in 256 KB units from address zero. Below the boundary, scratch-pad space is spread across the banks in 64-byte steps. At or above it, the cache region is spread in 256-byte steps. The row field keeps the address bits that are not used for bank selection, so the two symmetric regions fill disjoint rows in every bank. The settings are only captured while the block is idle. A request at or beyond 4 MB is answered with an error and never reaches a bank.

Top module: `bank_router`

## Requirements
- R1: With mode_i = 1 (asymmetric), bank = addr[21:18] and row = addr[17:5].
- R2: With mode_i = 0 and addr[21:18] < spm_units_i (scratch-pad region), bank = addr[9:6] and row = {addr[21:10], addr[5]}.
- R3: With mode_i = 0 and addr[21:18] >= spm_units_i (cache region), bank = addr[11:8] and row = {addr[21:12], addr[7:5]}.
- R4: The region boundary sits at exactly spm_units_i × 256 KB. A value of 0 sends every address to the cache mapping, and a value of 16 sends every address to the scratch-pad mapping.
- R5: A valid request with any of addr[23:22] set gets req_ready_o and req_err_o high in the same cycle. It raises no bank enable and produces no response.
- R6: Each bank enable serves at most one requester per cycle. Requesters that target different banks are all accepted in the same cycle.
- R7: Each bank grants in round-robin order. The requester after the last one granted by that bank gets priority, and requester 0 comes first after reset.
- R8: A requester that loses arbitration sees req_ready_o low for that cycle, and it is served in a later cycle while it keeps its request steady.
- R9: A read granted in cycle t raises rsp_valid_o for that requester only in cycle t+1. It carries the bank_rdata_i slice of the bank that was granted.
- R10: mode_i and spm_units_i are captured only at a clock edge where no request is valid and no read is pending. A change made while busy has no effect on requests served before the block next goes idle.
- R11: A write drives bank_we_o and the requester's data on that bank's bank_wdata_o, and it produces no response.
- R12: During and right after reset, with no request presented, every ready, error, bank enable and response valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = asymmetric linear mapping, 0 = symmetric interleaved mapping |
| spm_units_i | input | 5 | Number of 256 KB units, starting at address 0, that use the scratch-pad mapping |
| req_valid_i | input | 4 | Request valid, one bit per requester |
| req_we_i | input | 4 | Write flag, one bit per requester |
| req_addr_i | input | 4×24 | Byte address, one 24-bit field per requester |
| req_wdata_i | input | 4×256 | Write data, one 256-bit field per requester |
| req_ready_o | output | 4 | Request accepted this cycle |
| req_err_o | output | 4 | Accepted request was out of range |
| rsp_valid_o | output | 4 | Read data valid on the requester's lane |
| rsp_rdata_o | output | 4×256 | Read data, one 256-bit field per requester |
| bank_en_o | output | 16 | Bank access enable |
| bank_we_o | output | 16 | Bank write enable |
| bank_row_o | output | 16×13 | Row index, one 13-bit field per bank |
| bank_wdata_o | output | 16×256 | Write data, one field per bank |
| bank_rdata_i | input | 16×256 | Registered read data from each bank, valid the cycle after its enable |

## Verification
The hardest situation to reach is a configuration change that arrives while a request is stalled behind a bank conflict. The change must stay invisible until the block goes idle. The bench holds two requesters on the same bank and flips the mode in the same cycle. It then checks that the stalled requester is still served through the old mapping. After an idle gap, it reissues the same address and expects the new bank. Round-robin order is reached by first steering a lone request to set a bank's last-granted pointer, and then presenting a contention pattern whose winner differs between fixed priority and rotation.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;
  typedef enum logic [1:0] {
    MAP_SPM = 2'd0,
    MAP_L2  = 2'd1,
    MAP_LIN = 2'd2
  } map_kind_e;
endpackage

// File: rtl/bank_addr_map.sv
module bank_addr_map
  import bank_router_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 22,
  parameter int BANK_W = 4,
  parameter int OFF_W  = 5,
  parameter int SPM_SH = 6,
  parameter int L2_SH  = 8,
  parameter int ROW_W  = 13,
  parameter int UNIT_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              asym_i,
  input  logic [UNIT_W-1:0] spm_units_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              err_o
);
  localparam int BANK_AW = MEM_AW - BANK_W;
  localparam logic [MEM_AW-1:0] SPM_LO = MEM_AW'((1 << (SPM_SH - OFF_W)) - 1);
  localparam logic [MEM_AW-1:0] L2_LO  = MEM_AW'((1 << (L2_SH - OFF_W)) - 1);

  logic [MEM_AW-1:0] a;
  logic [BANK_W-1:0] window;
  logic [MEM_AW-1:0] spm_row, l2_row;
  map_kind_e         kind;

  assign a      = addr_i[MEM_AW-1:0];
  assign err_o  = |addr_i[ADDR_W-1:MEM_AW];
  assign window = a[MEM_AW-1:BANK_AW];

  // bank-select bits are squeezed out, word offset dropped
  assign spm_row = ((a >> (SPM_SH + BANK_W)) << (SPM_SH - OFF_W)) | ((a >> OFF_W) & SPM_LO);
  assign l2_row  = ((a >> (L2_SH + BANK_W)) << (L2_SH - OFF_W)) | ((a >> OFF_W) & L2_LO);

  always_comb begin
    if (asym_i)                              kind = MAP_LIN;
    else if (UNIT_W'(window) < spm_units_i)  kind = MAP_SPM;
    else                                     kind = MAP_L2;
  end

  always_comb begin
    unique case (kind)
      MAP_SPM: begin bank_o = a[SPM_SH +: BANK_W]; row_o = ROW_W'(spm_row); end
      MAP_L2:  begin bank_o = a[L2_SH +: BANK_W];  row_o = ROW_W'(l2_row);  end
      default: begin bank_o = window;              row_o = a[BANK_AW-1:OFF_W]; end
    endcase
  end
endmodule

// File: rtl/bank_rr_arb.sv
module bank_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] win_idx;
  logic             found;

  always_comb begin
    gnt_o   = '0;
    found   = 1'b0;
    win_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        win_idx    = IDX_W'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IDX_W'(N - 1);
    else if (found) last_q <= win_idx;
  end

  assert_one_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_grant_needs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  assert_no_idle_bank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/bank_router.sv
module bank_router #(
  parameter int NUM_REQ    = 4,
  parameter int NUM_BANKS  = 16,
  parameter int BANK_BYTES = 262144,
  parameter int WORD_BYTES = 32,
  parameter int SPM_GRAN   = 64,
  parameter int L2_GRAN    = 256,
  parameter int ADDR_W     = 24,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int OFF_W   = $clog2(WORD_BYTES),
  localparam int BANK_AW = $clog2(BANK_BYTES),
  localparam int MEM_AW  = BANK_AW + BANK_W,
  localparam int ROW_W   = BANK_AW - OFF_W,
  localparam int DATA_W  = WORD_BYTES * 8,
  localparam int UNIT_W  = $clog2(NUM_BANKS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           mode_i,
  input  logic [UNIT_W-1:0]              spm_units_i,
  input  logic [NUM_REQ-1:0]             req_valid_i,
  input  logic [NUM_REQ-1:0]             req_we_i,
  input  logic [NUM_REQ*ADDR_W-1:0]      req_addr_i,
  input  logic [NUM_REQ*DATA_W-1:0]      req_wdata_i,
  output logic [NUM_REQ-1:0]             req_ready_o,
  output logic [NUM_REQ-1:0]             req_err_o,
  output logic [NUM_REQ-1:0]             rsp_valid_o,
  output logic [NUM_REQ*DATA_W-1:0]      rsp_rdata_o,
  output logic [NUM_BANKS-1:0]           bank_en_o,
  output logic [NUM_BANKS-1:0]           bank_we_o,
  output logic [NUM_BANKS*ROW_W-1:0]     bank_row_o,
  output logic [NUM_BANKS*DATA_W-1:0]    bank_wdata_o,
  input  logic [NUM_BANKS*DATA_W-1:0]    bank_rdata_i
);
  localparam int SPM_SH = $clog2(SPM_GRAN);
  localparam int L2_SH  = $clog2(L2_GRAN);
  localparam int RID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic              cfg_asym_q;
  logic [UNIT_W-1:0] cfg_units_q;
  logic              busy;

  logic [BANK_W-1:0] map_bank [NUM_REQ];
  logic [ROW_W-1:0]  map_row  [NUM_REQ];
  logic [NUM_REQ-1:0] map_err;
  logic [NUM_REQ-1:0] gnt_any;

  logic [NUM_REQ-1:0] breq [NUM_BANKS];
  logic [NUM_REQ-1:0] bgnt [NUM_BANKS];
  logic [RID_W-1:0]   sel  [NUM_BANKS];

  logic [NUM_BANKS-1:0] rd_pend_q;
  logic [RID_W-1:0]     rd_id_q [NUM_BANKS];

  // configuration only moves while nothing is in flight
  assign busy = (|req_valid_i) | (|rd_pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_asym_q  <= 1'b0;
      cfg_units_q <= '0;
    end else if (!busy) begin
      cfg_asym_q  <= mode_i;
      cfg_units_q <= spm_units_i;
    end
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_map
    bank_addr_map #(
      .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .BANK_W(BANK_W), .OFF_W(OFF_W),
      .SPM_SH(SPM_SH), .L2_SH(L2_SH), .ROW_W(ROW_W), .UNIT_W(UNIT_W)
    ) u_map (
      .addr_i      (req_addr_i[r*ADDR_W +: ADDR_W]),
      .asym_i      (cfg_asym_q),
      .spm_units_i (cfg_units_q),
      .bank_o      (map_bank[r]),
      .row_o       (map_row[r]),
      .err_o       (map_err[r])
    );
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        breq[b][r] = req_valid_i[r] && !map_err[r] && (map_bank[r] == BANK_W'(b));
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_arb
    bank_rr_arb #(.N(NUM_REQ)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (breq[b]),
      .gnt_o  (bgnt[b])
    );
  end

  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      gnt_any[r] = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) gnt_any[r] = gnt_any[r] | bgnt[b][r];
    end
  end

  assign req_err_o   = req_valid_i & map_err;
  assign req_ready_o = req_valid_i & (map_err | gnt_any);

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      sel[b] = '0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (bgnt[b][r]) sel[b] = RID_W'(r);
      end
      bank_en_o[b] = |bgnt[b];
      bank_we_o[b] = bank_en_o[b] & req_we_i[sel[b]];
      bank_row_o[b*ROW_W +: ROW_W]    = map_row[sel[b]];
      bank_wdata_o[b*DATA_W +: DATA_W] = req_wdata_i[int'(sel[b])*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++) rd_id_q[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        rd_pend_q[b] <= bank_en_o[b] & ~bank_we_o[b];
        rd_id_q[b]   <= sel[b];
      end
    end
  end

  always_comb begin
    rsp_valid_o = '0;
    rsp_rdata_o = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (rd_pend_q[b] && int'(rd_id_q[b]) == r) begin
          rsp_valid_o[r] = 1'b1;
          rsp_rdata_o[r*DATA_W +: DATA_W] = rsp_rdata_o[r*DATA_W +: DATA_W]
                                            | bank_rdata_i[b*DATA_W +: DATA_W];
        end
      end
    end
  end

  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(cfg_asym_q) && $stable(cfg_units_q)));

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req_chk
    assert_err_blocks_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[r] && map_err[r]) |-> !gnt_any[r]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    assert_read_returns_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_en_o[b] && !bank_we_o[b]) |=> (|rsp_valid_o));
  end
endmodule

// File: tb/bank_router_bench.sv
module bank_router_bench;
  localparam int NR = 4;
  localparam int NB = 16;
  localparam int AW = 24;
  localparam int DW = 256;
  localparam int RW = 13;
  localparam int UNIT = 262144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [4:0] units = '0;
  logic [NR-1:0] req_valid = '0;
  logic [NR-1:0] req_we = '0;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR*DW-1:0] req_wdata = '0;
  logic [NR-1:0] ready, err, rsp_valid;
  logic [NR*DW-1:0] rsp_rdata;
  logic [NB-1:0] bank_en, bank_we;
  logic [NB*RW-1:0] bank_row;
  logic [NB*DW-1:0] bank_wdata;
  logic [NB*DW-1:0] bank_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit cur_asym = 1'b0;
  int cur_units = 0;

  always #4 clk = ~clk;

  bank_router u_bank_router (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .spm_units_i(units),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(ready), .req_err_o(err),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bank_en_o(bank_en), .bank_we_o(bank_we), .bank_row_o(bank_row),
    .bank_wdata_o(bank_wdata), .bank_rdata_i(bank_rdata)
  );

  function automatic logic [DW-1:0] pat(input int b, input int row);
    return {16{16'(row)}} ^ (DW'(b + 1) << 200);
  endfunction

  // bank storage stand-in: registered read of a pattern
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (bank_en[b] && !bank_we[b]) bank_rdata[b*DW +: DW] <= pat(b, int'(bank_row[b*RW +: RW]));
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_map(input int addr, output int bk, output int rw, output string tag);
    if (cur_asym) begin
      bk = addr / UNIT; rw = (addr % UNIT) / 32; tag = "R1";
    end else if (addr / UNIT < cur_units) begin
      bk = (addr / 64) % 16; rw = (addr / 1024) * 2 + (addr / 32) % 2; tag = "R2";
    end else begin
      bk = (addr / 256) % 16; rw = (addr / 4096) * 8 + (addr / 32) % 8; tag = "R3";
    end
  endtask

  task automatic set_cfg(input bit asym, input int u);
    @(negedge clk);
    mode = asym; units = 5'(u);
    cur_asym = asym; cur_units = u;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input int r, input int addr, input string force_tag);
    int bk, rw; string tag;
    exp_map(addr, bk, rw, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    req_valid[r] = 1'b1; req_we[r] = 1'b0;
    req_addr[r*AW +: AW] = AW'(addr);
    #1;
    check(ready == (NR'(1) << r), {tag, " ready"}, ready, NR'(1) << r);
    check(bank_en == (NB'(1) << bk), {tag, " bank"}, bank_en, NB'(1) << bk);
    check(int'(bank_row[bk*RW +: RW]) == rw && !bank_we[bk], {tag, " row"},
          bank_row[bk*RW +: RW], rw);
    @(negedge clk);
    req_valid[r] = 1'b0;
    #1;
    check(rsp_valid == (NR'(1) << r), "R9 rsp valid", rsp_valid, NR'(1) << r);
    check(rsp_rdata[r*DW +: DW] == pat(bk, rw), "R9 rsp data",
          rsp_rdata[r*DW +: 64], pat(bk, rw) & 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int bk, rw; string tag;
    repeat (3) @(negedge clk);
    check(ready == 0 && err == 0 && bank_en == 0 && rsp_valid == 0, "R12 in reset",
          {ready, err, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 0 && err == 0 && bank_en == 0 && rsp_valid == 0, "R12 after reset",
          {ready, err, rsp_valid}, 0);

    // address sweeps across mapping configurations (R1, R2, R3)
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: set_cfg(1'b1, 0);
        1: set_cfg(1'b0, 0);
        2: set_cfg(1'b0, 16);
        default: set_cfg(1'b0, 7);
      endcase
      for (int i = 0; i < 160; i++) begin
        int addr;
        addr = (i * 26227 + i * i * 131 + (i % 32)) % 4194304;
        do_read(i % NR, addr, "");
      end
    end

    // region boundary (R4)
    set_cfg(1'b0, 5);
    do_read(0, 5 * UNIT - 32, "R4 below");
    do_read(1, 5 * UNIT, "R4 at");
    set_cfg(1'b0, 0);
    do_read(2, 0, "R4 zero");
    set_cfg(1'b0, 16);
    do_read(3, 4194304 - 1, "R4 full");

    // out of range (R5)
    for (int k = 0; k < 2; k++) begin
      int a;
      a = (k == 0) ? 4194304 + 64 : 16777184;
      @(negedge clk);
      req_valid[2] = 1'b1; req_we[2] = 1'b0; req_addr[2*AW +: AW] = AW'(a);
      #1;
      check(ready == 4'b0100 && err == 4'b0100, "R5 ready/err", {ready, err}, 8'h44);
      check(bank_en == 0, "R5 no bank", bank_en, 0);
      @(negedge clk);
      req_valid[2] = 1'b0;
      #1;
      check(rsp_valid == 0, "R5 no rsp", rsp_valid, 0);
    end

    // distinct banks in parallel (R6)
    set_cfg(1'b1, 0);
    @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      req_valid[r] = 1'b1; req_we[r] = 1'b0;
      req_addr[r*AW +: AW] = AW'(r * 3 * UNIT + r * 64);
    end
    #1;
    check(ready == 4'hF, "R6 all ready", ready, 4'hF);
    check(bank_en == 16'h0249, "R6 bank mask", bank_en, 16'h0249);
    @(negedge clk);
    req_valid = '0;
    #1;
    check(rsp_valid == 4'hF, "R9 parallel rsp", rsp_valid, 4'hF);
    for (int r = 0; r < NR; r++)
      check(rsp_rdata[r*DW +: DW] == pat(r * 3, r * 2), "R9 parallel data",
            rsp_rdata[r*DW +: 64], pat(r * 3, r * 2) & 64'hFFFF_FFFF_FFFF_FFFF);

    // contention on bank 2, pointer primed to requester 3 (R6, R7, R8)
    do_read(3, 2 * UNIT, "R7 prime");
    @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      req_valid[r] = 1'b1; req_we[r] = 1'b0;
      req_addr[r*AW +: AW] = AW'(2 * UNIT + (r + 1) * 32);
    end
    for (int k = 0; k < NR; k++) begin
      #1;
      check(ready == (NR'(1) << k), "R7 rr order", ready, NR'(1) << k);
      check(bank_en == 16'h0004 && int'(bank_row[2*RW +: RW]) == k + 1, "R8 held row",
            bank_row[2*RW +: RW], k + 1);
      if (k > 0)
        check(rsp_valid == (NR'(1) << (k - 1)), "R9 staged rsp", rsp_valid, NR'(1) << (k - 1));
      @(negedge clk);
      req_valid[k] = 1'b0;
    end
    #1;
    check(rsp_valid == 4'b1000, "R9 last staged rsp", rsp_valid, 4'b1000);

    // rotation vs fixed priority (R7)
    do_read(1, 5 * UNIT, "R7 prime2");
    @(negedge clk);
    req_valid[0] = 1'b1; req_we[0] = 1'b0; req_addr[0 +: AW] = AW'(5 * UNIT + 64);
    req_valid[2] = 1'b1; req_we[2] = 1'b0; req_addr[2*AW +: AW] = AW'(5 * UNIT + 96);
    #1;
    check(ready == 4'b0100, "R7 after 1 picks 2", ready, 4'b0100);
    @(negedge clk);
    req_valid[2] = 1'b0;
    #1;
    check(ready == 4'b0001, "R8 loser served next", ready, 4'b0001);
    @(negedge clk);
    req_valid[0] = 1'b0;
    @(negedge clk);

    // config change during a stall (R10)
    set_cfg(1'b1, 0);
    @(negedge clk);
    req_valid[0] = 1'b1; req_we[0] = 1'b0; req_addr[0 +: AW] = AW'(32'h0C0100);
    req_valid[1] = 1'b1; req_we[1] = 1'b0; req_addr[AW +: AW] = AW'(32'h0C0100);
    mode = 1'b0; units = 5'd0;
    #1;
    check($countones(ready) == 1 && bank_en == 16'h0008, "R10 first old map", bank_en, 16'h0008);
    begin
      logic [NR-1:0] won;
      won = ready;
      @(negedge clk);
      req_valid = req_valid & ~won;
      #1;
      check(bank_en == 16'h0008 && int'(bank_row[3*RW +: RW]) == 8, "R10 stalled old map",
            bank_en, 16'h0008);
      @(negedge clk);
      req_valid = '0;
    end
    cur_asym = 1'b0; cur_units = 0;
    @(negedge clk);
    @(negedge clk);
    exp_map(32'h0C0100, bk, rw, tag);
    do_read(0, 32'h0C0100, "R10 new map");

    // writes (R11)
    set_cfg(1'b0, 4);
    for (int k = 0; k < 3; k++) begin
      int a;
      logic [DW-1:0] wd;
      a = k * 1200000 + 4160;
      wd = {8{32'hA500_0000 + 32'(k)}};
      exp_map(a, bk, rw, tag);
      @(negedge clk);
      req_valid[1] = 1'b1; req_we[1] = 1'b1; req_addr[AW +: AW] = AW'(a);
      req_wdata[DW +: DW] = wd;
      #1;
      check(bank_en == (NB'(1) << bk) && bank_we[bk], "R11 write enable", bank_we, NB'(1) << bk);
      check(bank_wdata[bk*DW +: DW] == wd && int'(bank_row[bk*RW +: RW]) == rw, "R11 write data",
            bank_wdata[bk*DW +: 64], wd[63:0]);
      @(negedge clk);
      req_valid[1] = 1'b0; req_we[1] = 1'b0;
      #1;
      check(rsp_valid == 0, "R11 no rsp", rsp_valid, 0);
    end

    finish_run();
  end
endmodule